// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This controller is the master side of an 8-bit parallel configuration link to a target FPGA. On a load command it pulses the target's program pin for a fixed number of cycles. It then waits until the target reports that it has finished clearing its configuration memory. Next it enables the target's chip-select and write pins and takes bitstream bytes from a valid/ready stream. Each byte goes onto the data bus and is strobed with one low-then-high pulse of the configuration clock. When the last byte has gone out, the controller keeps clocking until the target raises its done pin.

A readback command selects the target, clocks a given number of bytes out of it and presents each byte on a one-cycle output strobe. After the select is released it issues one more clock pulse.

The configuration clock is derived from the system clock. Every wait has a timeout that is counted in system cycles. Any timeout, and also an external abort, ends the operation, releases the pins and raises a one-cycle abort pulse. A 3-bit status code reports the result.

Top module: `fpga_par_loader`

## Requirements
- R1: A load starts when `cmd_start` is high and `cmd_read` is low in idle. `prog_o` is high for exactly PROG_CYC cycles, `status_o` changes to 1 (busy), and chip-select and write stay low during the pulse.
- R2: After the program pulse, data transfer starts only when `init_i` and `busy_i` are both low. If that has not happened after TIMEOUT = CLK_HZ/100 cycles, `status_o` becomes 3 and `abort_o` pulses once. The prog-low to status-change distance is exactly TIMEOUT cycles.
- R3: Before the first byte, `cs_o` and `wr_o` are high and `cclk_o` is high. Each accepted stream byte is put on `d_o`, which stays stable while `cclk_o` goes low for DIVIDER/2 cycles and then high. The target therefore captures every byte exactly once, in stream order.
- R4: When `busy_chk_en` is high and `busy_i` is high at the end of a byte's high half, another clock pulse is issued with the same byte and no new byte is accepted. If `busy_i` is still high after TIMEOUT cycles of pulsing, `status_o` becomes 4 and `abort_o` pulses.
- R5: After the byte marked with `s_last`, `cs_o` falls at least one cycle before `wr_o` falls.
- R6: After the data phase, clock pulses continue until `done_i` is high. The number of extra rising edges equals the number the target needs, and then `status_o` becomes 2. If `done_i` stays low for TIMEOUT cycles, `status_o` becomes 5 and `abort_o` pulses.
- R7: A readback starts when `cmd_start` and `cmd_read` are both high. It keeps `wr_o` and `d_oe_o` low, issues one clock pulse per byte and strobes `m_valid` with the value of `d_i` taken at the end of that pulse's high half. After `rd_len` bytes it releases `cs_o`, issues exactly one trailing pulse and then sets `status_o` to 2.
- R8: `cmd_abort` during any operation sets `status_o` to 6, pulses `abort_o` and drops `prog_o`, `cs_o` and `wr_o` on the next edge.
- R9: After reset, `prog_o`, `cs_o`, `wr_o`, `s_ready` and `m_valid` are low, `cclk_o` is high and `status_o` is 0 (idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start an operation (from idle) |
| cmd_read | input | 1 | With cmd_start: readback instead of load |
| cmd_abort | input | 1 | Abort the current operation |
| busy_chk_en | input | 1 | Honour target busy during the data phase |
| rd_len | input | LEN_W | Number of bytes to read back |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | DW | Stream byte |
| s_last | input | 1 | Marks the final stream byte |
| s_ready | output | 1 | Controller accepts a stream byte |
| m_valid | output | 1 | Readback byte strobe |
| m_data | output | DW | Readback byte |
| prog_o | output | 1 | Target program pin (1 = asserted) |
| cs_o | output | 1 | Target chip-select (1 = asserted) |
| wr_o | output | 1 | Target write-enable (1 = asserted) |
| cclk_o | output | 1 | Configuration clock |
| d_o | output | DW | Data bus towards the target |
| d_oe_o | output | 1 | Data bus drive enable |
| d_i | input | DW | Data bus from the target |
| init_i | input | 1 | Target still initialising (1 = busy) |
| busy_i | input | 1 | Target busy |
| done_i | input | 1 | Target configured |
| abort_o | output | 1 | One-cycle pulse on timeout or abort |
| status_o | output | 3 | 0 idle, 1 busy, 2 ok, 3 init timeout, 4 busy timeout, 5 done timeout, 6 aborted |

## Verification
Each output has a fixed due cycle after its stimulus. The program pin rises and the status turns busy on the edge that takes the start command. The pin falls PROG_CYC edges later. The init timeout is due exactly TIMEOUT edges after that. An abort shows on the edge that samples it, and every clock-low half lasts DIVIDER/2 edges. The bench samples all of these on falling edges and measures the distances with a cycle counter. The target model also reacts on falling edges, so any change it makes is seen at the next rising edge. Byte capture, the extra busy pulses, the done-phase pulse count and the trailing readback pulse are all counted from observed rising edges of the configuration clock, so those results do not depend on the exact edge at which they occur.

// File: rtl/fpga_par_loader.sv
module fpga_par_loader #(
  parameter int DW       = 8,
  parameter int LEN_W    = 16,
  parameter int CLK_HZ   = 50_000_000,
  parameter int DIVIDER  = 4,
  parameter int PROG_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_read,
  input  logic             cmd_abort,
  input  logic             busy_chk_en,
  input  logic [LEN_W-1:0] rd_len,
  input  logic             s_valid,
  input  logic [DW-1:0]    s_data,
  input  logic             s_last,
  output logic             s_ready,
  output logic             m_valid,
  output logic [DW-1:0]    m_data,
  output logic             prog_o,
  output logic             cs_o,
  output logic             wr_o,
  output logic             cclk_o,
  output logic [DW-1:0]    d_o,
  output logic             d_oe_o,
  input  logic [DW-1:0]    d_i,
  input  logic             init_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             abort_o,
  output logic [2:0]       status_o
);
  localparam int TIMEOUT = (CLK_HZ / 100 < 2) ? 2 : CLK_HZ / 100;
  localparam int HALF    = (DIVIDER < 2) ? 1 : DIVIDER / 2;
  localparam int TW      = $clog2(TIMEOUT + 1);
  localparam int PW      = $clog2(PROG_CYC + 1);
  localparam int HW      = $clog2(HALF + 1);
  localparam int CW      = (PW > HW) ? PW : HW;

  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_BUSY  = 3'd1;
  localparam logic [2:0] ST_OK    = 3'd2;
  localparam logic [2:0] ST_TINIT = 3'd3;
  localparam logic [2:0] ST_TBUSY = 3'd4;
  localparam logic [2:0] ST_TDONE = 3'd5;
  localparam logic [2:0] ST_ABORT = 3'd6;

  typedef enum logic [4:0] {
    S_IDLE, S_PROG, S_WAIT, S_FETCH, S_LO, S_HI, S_CSOFF, S_WROFF,
    S_DCHK, S_DLO, S_DHI, S_RSET, S_RLO, S_RHI, S_RCSOFF, S_TLO, S_THI
  } state_t;

  state_t           state;
  logic [CW-1:0]    cnt;
  logic [TW-1:0]    tmo;
  logic [LEN_W-1:0] rcnt, len_q;
  logic [DW-1:0]    d_q;
  logic             last_q;

  logic          half_end, tmo_end;
  logic [TW-1:0] tmo_inc;

  assign half_end = (cnt == CW'(HALF - 1));
  assign tmo_end  = (tmo == TW'(TIMEOUT - 1));
  assign tmo_inc  = tmo_end ? tmo : tmo + TW'(1);

  assign prog_o  = (state == S_PROG);
  assign cs_o    = state inside {S_FETCH, S_LO, S_HI, S_RSET, S_RLO, S_RHI};
  assign wr_o    = state inside {S_FETCH, S_LO, S_HI, S_CSOFF};
  assign cclk_o  = !(state inside {S_LO, S_DLO, S_RLO, S_TLO});
  assign d_oe_o  = wr_o;
  assign d_o     = d_q;
  assign s_ready = (state == S_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      tmo      <= '0;
      rcnt     <= '0;
      len_q    <= '0;
      d_q      <= '0;
      last_q   <= 1'b0;
      m_valid  <= 1'b0;
      m_data   <= '0;
      abort_o  <= 1'b0;
      status_o <= ST_IDLE;
    end else begin
      abort_o <= 1'b0;
      m_valid <= 1'b0;
      if (cmd_abort && state != S_IDLE) begin
        state    <= S_IDLE;
        status_o <= ST_ABORT;
        abort_o  <= 1'b1;
      end else begin
        case (state)
          S_IDLE: if (cmd_start) begin
            status_o <= ST_BUSY;
            cnt      <= '0;
            rcnt     <= '0;
            len_q    <= rd_len;
            state    <= cmd_read ? S_RSET : S_PROG;
          end
          S_PROG: if (cnt == CW'(PROG_CYC - 1)) begin
            tmo   <= '0;
            state <= S_WAIT;
          end else cnt <= cnt + CW'(1);
          S_WAIT: if (!init_i && !busy_i) state <= S_FETCH;
          else if (tmo_end) begin
            state    <= S_IDLE;
            status_o <= ST_TINIT;
            abort_o  <= 1'b1;
          end else tmo <= tmo_inc;
          S_FETCH: if (s_valid) begin
            d_q    <= s_data;
            last_q <= s_last;
            cnt    <= '0;
            tmo    <= '0;
            state  <= S_LO;
          end
          S_LO, S_DLO: begin
            tmo <= tmo_inc;
            if (half_end) begin
              cnt   <= '0;
              state <= (state == S_LO) ? S_HI : S_DHI;
            end else cnt <= cnt + CW'(1);
          end
          S_HI: begin
            tmo <= tmo_inc;
            if (half_end) begin
              cnt <= '0;
              if (busy_chk_en && busy_i) begin
                if (tmo_end) begin
                  state    <= S_IDLE;
                  status_o <= ST_TBUSY;
                  abort_o  <= 1'b1;
                end else state <= S_LO;
              end else state <= last_q ? S_CSOFF : S_FETCH;
            end else cnt <= cnt + CW'(1);
          end
          S_CSOFF: state <= S_WROFF;
          S_WROFF: begin
            tmo   <= '0;
            state <= S_DCHK;
          end
          S_DCHK: if (done_i) begin
            state    <= S_IDLE;
            status_o <= ST_OK;
          end else if (tmo_end) begin
            state    <= S_IDLE;
            status_o <= ST_TDONE;
            abort_o  <= 1'b1;
          end else begin
            tmo   <= tmo_inc;
            cnt   <= '0;
            state <= S_DLO;
          end
          S_DHI: begin
            tmo <= tmo_inc;
            if (half_end) begin
              cnt   <= '0;
              state <= S_DCHK;
            end else cnt <= cnt + CW'(1);
          end
          S_RSET: begin
            cnt   <= '0;
            state <= (len_q == '0) ? S_RCSOFF : S_RLO;
          end
          S_RLO, S_TLO: if (half_end) begin
            cnt   <= '0;
            state <= (state == S_RLO) ? S_RHI : S_THI;
          end else cnt <= cnt + CW'(1);
          S_RHI: if (half_end) begin
            cnt     <= '0;
            m_data  <= d_i;
            m_valid <= 1'b1;
            rcnt    <= rcnt + LEN_W'(1);
            state   <= (rcnt + LEN_W'(1) == len_q) ? S_RCSOFF : S_RLO;
          end else cnt <= cnt + CW'(1);
          S_RCSOFF: begin
            cnt   <= '0;
            state <= S_TLO;
          end
          S_THI: if (half_end) begin
            state    <= S_IDLE;
            status_o <= ST_OK;
          end else cnt <= cnt + CW'(1);
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fpga_par_loader_chk.sv
module fpga_par_loader_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_abort,
  input logic          prog_o,
  input logic          cs_o,
  input logic          wr_o,
  input logic          cclk_o,
  input logic          d_oe_o,
  input logic          m_valid,
  input logic          abort_o,
  input logic [DW-1:0] d_o,
  input logic [2:0]    status_o
);
  assert_prog_alone_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o |-> !cs_o && !wr_o && status_o == 3'd1);

  assert_fail_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> status_o >= 3'd3 && status_o <= 3'd6);

  assert_byte_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_o && wr_o && !cclk_o && $past(cs_o && wr_o && !cclk_o) |-> $stable(d_o));

  assert_cs_before_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_o) && status_o == 3'd1 |-> !$past(cs_o));

  assert_rb_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !wr_o && !d_oe_o);

  assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_abort) && $past(status_o) == 3'd1 |->
      status_o == 3'd6 && !cs_o && !wr_o && !prog_o && abort_o);
endmodule

bind fpga_par_loader fpga_par_loader_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_abort(cmd_abort), .prog_o(prog_o),
  .cs_o(cs_o), .wr_o(wr_o), .cclk_o(cclk_o), .d_oe_o(d_oe_o),
  .m_valid(m_valid), .abort_o(abort_o), .d_o(d_o), .status_o(status_o)
);

// File: tb/fpga_par_loader_test.sv
`timescale 1ns/1ps
module fpga_par_loader_test;
  localparam int CLK_HZ   = 10_000;
  localparam int TIMEOUT  = CLK_HZ / 100;
  localparam int DIVIDER  = 4;
  localparam int HALF     = DIVIDER / 2;
  localparam int PROG_CYC = 8;
  localparam int NV       = 7;

  // fields: nbytes, busy_chk, stall_at, stall_len, init_dly, done_clks, exp_status
  localparam logic [55:0] VECS [NV] = '{
    {8'd4, 8'd0, 8'd0, 8'd0,   8'd5,   8'd3,   8'd2},
    {8'd1, 8'd0, 8'd0, 8'd0,   8'd0,   8'd0,   8'd2},
    {8'd6, 8'd1, 8'd2, 8'd3,   8'd10,  8'd1,   8'd2},
    {8'd3, 8'd1, 8'd0, 8'd200, 8'd2,   8'd1,   8'd4},
    {8'd2, 8'd0, 8'd0, 8'd0,   8'd255, 8'd0,   8'd3},
    {8'd2, 8'd0, 8'd0, 8'd0,   8'd1,   8'd255, 8'd5},
    {8'd5, 8'd1, 8'd4, 8'd1,   8'd3,   8'd2,   8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_read = 0, cmd_abort = 0, busy_chk_en = 0;
  logic [15:0] rd_len = '0;
  logic s_valid = 0, s_last = 0, s_ready, m_valid;
  logic [7:0] s_data = '0, m_data, d_o, d_i = '0;
  logic prog_o, cs_o, wr_o, cclk_o, d_oe_o, abort_o;
  logic init_i = 0, busy_i = 0, done_i = 0;
  logic [2:0] status_o;

  always #10 clk = ~clk;

  fpga_par_loader #(.DW(8), .LEN_W(16), .CLK_HZ(CLK_HZ), .DIVIDER(DIVIDER),
                    .PROG_CYC(PROG_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read),
    .cmd_abort(cmd_abort), .busy_chk_en(busy_chk_en), .rd_len(rd_len),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .m_valid(m_valid), .m_data(m_data), .prog_o(prog_o), .cs_o(cs_o),
    .wr_o(wr_o), .cclk_o(cclk_o), .d_o(d_o), .d_oe_o(d_oe_o), .d_i(d_i),
    .init_i(init_i), .busy_i(busy_i), .done_i(done_i), .abort_o(abort_o),
    .status_o(status_o));

  int checks = 0, fails = 0;
  int cyc = 0, t_pr = 0, t_pf = 0, t_end = 0;
  int cur_v = 0, cur_n = 0, s_idx = 0, stall_at = 0, stall_len = 0, stall_left = 0;
  int init_dly = 0, iw = 0, done_k = 0, dclk = 0, lo_run = 0;
  int rx_n = 0, m_n = 0, rb_idx = 0, trail = 0, ab_n = 0;
  logic xf = 0, prev_prog = 0, prev_cclk = 1, prev_wr = 0, prev_cs = 0;
  logic [2:0] prev_status = '0;
  logic wr_fell = 0, order_bad = 0, bad_half = 0, rb_on = 0;
  logic [7:0] rx [64];
  logic [7:0] mbuf [16];

  function automatic logic [7:0] pat(int v, int i);
    return 8'((i * 37 + v * 11 + 5) & 255);
  endfunction

  function automatic logic [7:0] rb_pat(int i);
    return 8'(8'hA0 + i * 7);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic rise;
    @(negedge clk);
    cyc++;
    if (xf) begin
      s_idx++;
      if (s_idx >= cur_n) s_valid = 0;
      else s_data = pat(cur_v, s_idx);
      s_last = (s_idx == cur_n - 1);
    end
    xf = s_valid && s_ready;
    if (prog_o && !prev_prog) t_pr = cyc;
    if (!prog_o && prev_prog) t_pf = cyc;
    if (prog_o) begin
      init_i = 1; busy_i = 0; done_i = 0; iw = init_dly;
    end else if (init_i) begin
      if (iw == 0) init_i = 0;
      else if (iw != 255) iw--;
    end
    if (!cclk_o) lo_run++;
    rise = cclk_o && !prev_cclk;
    if (rise) begin
      if (lo_run != HALF) bad_half = 1;
      lo_run = 0;
    end
    if (rise && cs_o && wr_o) begin
      if (busy_i) begin
        stall_left--;
        if (stall_left <= 0) busy_i = 0;
      end else begin
        if (rx_n < 64) rx[rx_n] = d_o;
        rx_n++;
        if (rx_n - 1 == stall_at && stall_len != 0) begin
          busy_i = 1; stall_left = stall_len;
        end
      end
    end
    if (!wr_o && prev_wr) begin
      wr_fell = 1;
      if (prev_cs) order_bad = 1;
      if (done_k == 0) done_i = 1;
    end
    if (rise && !cs_o && !wr_o && wr_fell) begin
      dclk++;
      if (dclk == done_k && done_k != 255) done_i = 1;
    end
    if (rise && cs_o && !wr_o) begin
      d_i = rb_pat(rb_idx); rb_idx++; rb_on = 1;
    end else if (rise && !cs_o && rb_on) trail++;
    if (m_valid) begin
      if (m_n < 16) mbuf[m_n] = m_data;
      m_n++;
    end
    if (abort_o) ab_n++;
    if (status_o != 3'd1 && prev_status == 3'd1) t_end = cyc;
    prev_prog = prog_o; prev_cclk = cclk_o; prev_wr = wr_o; prev_cs = cs_o;
    prev_status = status_o;
  endtask

  task automatic clear_model();
    rx_n = 0; m_n = 0; rb_idx = 0; trail = 0; ab_n = 0; dclk = 0; lo_run = 0;
    wr_fell = 0; order_bad = 0; bad_half = 0; rb_on = 0; xf = 0; s_idx = 0;
  endtask

  task automatic start_op(bit rd);
    cmd_start = 1; cmd_read = rd;
    tick();
    cmd_start = 0; cmd_read = 0;
    for (int k = 0; k < 3000 && status_o == 3'd1; k++) tick();
    tick();
  endtask

  task automatic run_vec(int v);
    logic [55:0] e;
    int exp_st;
    e = VECS[v];
    clear_model();
    cur_v = v; cur_n = int'(e[55:48]); busy_chk_en = e[40];
    stall_at = int'(e[39:32]); stall_len = int'(e[31:24]);
    init_dly = int'(e[23:16]); done_k = int'(e[15:8]); exp_st = int'(e[7:0]);
    s_valid = (cur_n > 0); s_data = pat(v, 0); s_last = (cur_n == 1);
    start_op(0);
    s_valid = 0;
    check(status_o == 3'(exp_st), $sformatf("R6 status vec %0d", v), status_o, exp_st);
    check(t_pf - t_pr == PROG_CYC, $sformatf("R1 prog width vec %0d", v), t_pf - t_pr, PROG_CYC);
    if (exp_st == 2) begin
      check(rx_n == cur_n, $sformatf("R3 bytes captured vec %0d", v), rx_n, cur_n);
      for (int i = 0; i < cur_n && i < 64; i++)
        check(rx[i] == pat(v, i), $sformatf("R3 R4 byte %0d vec %0d", i, v), rx[i], pat(v, i));
      check(dclk == done_k, $sformatf("R6 done clocks vec %0d", v), dclk, done_k);
      check(!order_bad, $sformatf("R5 cs before wr vec %0d", v), order_bad, 0);
      check(!bad_half, $sformatf("R3 low half width vec %0d", v), bad_half, 0);
      check(ab_n == 0, $sformatf("R6 no abort vec %0d", v), ab_n, 0);
    end else begin
      check(ab_n == 1, $sformatf("R2 R4 R6 abort pulse vec %0d", v), ab_n, 1);
      check(!cs_o && !wr_o && !prog_o, $sformatf("R2 pins released vec %0d", v),
            {cs_o, wr_o, prog_o}, 0);
    end
    if (exp_st == 3)
      check(t_end - t_pf == TIMEOUT, "R2 init timeout distance", t_end - t_pf, TIMEOUT);
  endtask

  initial begin
    #3_000_000;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R9 reset state
    check(!prog_o && !cs_o && !wr_o, "R9 pins low", {prog_o, cs_o, wr_o}, 0);
    check(cclk_o == 1, "R9 cclk parked high", cclk_o, 1);
    check(status_o == 3'd0, "R9 status idle", status_o, 0);
    check(!s_ready && !m_valid, "R9 no handshake", {s_ready, m_valid}, 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R7 readback of three bytes
    clear_model();
    rd_len = 16'd3;
    start_op(1);
    check(status_o == 3'd2, "R7 readback status", status_o, 2);
    check(m_n == 3, "R7 readback strobes", m_n, 3);
    for (int i = 0; i < 3; i++)
      check(mbuf[i] == rb_pat(i), $sformatf("R7 readback byte %0d", i), mbuf[i], rb_pat(i));
    check(trail == 1, "R7 trailing pulse", trail, 1);
    check(!bad_half, "R7 low half width", bad_half, 0);

    // R8 abort during the wait for init
    clear_model();
    init_dly = 255;
    cmd_start = 1;
    tick();
    cmd_start = 0;
    for (int k = 0; k < 20; k++) tick();
    check(status_o == 3'd1, "R8 busy before abort", status_o, 1);
    cmd_abort = 1;
    tick();
    cmd_abort = 0;
    check(status_o == 3'd6, "R8 status aborted", status_o, 6);
    check(!prog_o && !cs_o && !wr_o, "R8 pins released", {prog_o, cs_o, wr_o}, 0);
    check(ab_n == 1, "R8 abort pulse", ab_n, 1);
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule